// File: doc/BRIEF.md
# EEPROM Image Checksum Cache

This block sits between a client and a serial EEPROM word engine. It holds a 64-word local copy of the EEPROM image, 16 bits per word. A load walks the whole image from word 0 upward. For each word it issues a single-word read, adds the word into a wrapping 16-bit sum and stores it in the cache. At the end of the walk it judges the image. The image is accepted only when the sum equals 0xBABA and the signature field of the control word reads "valid". The signature field is bits 15:14 of word 10, with 2'b01 meaning valid. The cache counts as valid exactly while a copy of that signature field, held in a register, reads 2'b01. Any write toward the EEPROM clears that copy.

A client sends one operation at a time: load, lookup, checksum update or word write. A lookup served from a valid cache produces no EEPROM traffic. When the cache is invalid, the lookup first reloads the whole image and returns the word only if the reload succeeds. A checksum update sums words 0 through 62 as they are read from the EEPROM. It then writes 0xBABA minus that sum into word 63.

The controller is one state machine with these states: IDLE (waits for an operation), RD_ISSUE (one-cycle read request), RD_WAIT (waits for the engine to finish), SUM_EVAL (judges the sum, or forms the checksum word), WR_ISSUE (one-cycle write request), WR_WAIT (waits for the write to finish) and FINISH (one-cycle completion). The transitions are:
- IDLE goes to RD_ISSUE for a load, an update or a lookup that misses. It goes to WR_ISSUE for a word write, and to FINISH for a lookup that hits or has an index out of range.
- RD_ISSUE goes to RD_WAIT.
- RD_WAIT goes back to RD_ISSUE until the last word returns, then goes to SUM_EVAL.
- SUM_EVAL goes to WR_ISSUE for an update and to FINISH otherwise.
- WR_ISSUE goes to WR_WAIT. WR_WAIT goes to FINISH on completion. FINISH goes to IDLE.

Top module: `ee_image_cache`

## Requirements
- R1: After reset, busy, done, ee_req, stat_valid, stat_sum_err and stat_sig_err are all 0.
- R2: A load, and the reload triggered by a lookup miss, reads exactly 64 words, with addresses rising from 0 to 63, and never has more than one request outstanding.
- R3: When the loaded sum equals 0xBABA and bits 15:14 of word 10 equal 2'b01, the load ends with stat_valid=1, stat_sum_err=0 and stat_sig_err=0.
- R4: When the loaded sum differs from 0xBABA, the load ends with stat_valid=0, stat_sum_err=1 and stat_sig_err=0.
- R5: When the sum matches but bits 15:14 of word 10 are not 2'b01, the load ends with stat_valid=0, stat_sig_err=1 and stat_sum_err=0.
- R6: A lookup with index below 64 on a valid cache returns the cached word on rd_data and issues no EEPROM request.
- R7: A lookup with index below 64 on an invalid cache first performs a full load. It then returns the EEPROM word if that load leaves the cache valid, and 0 otherwise.
- R8: A lookup with index 64 or higher returns 0, issues no EEPROM request and leaves the status unchanged.
- R9: An update (op_code 2) reads words 0 to 62, which is 63 reads. It then makes one write of 0xBABA minus their 16-bit sum to word 63, and leaves stat_valid=0.
- R10: A word write (op_code 3) makes one EEPROM write to address op_index[5:0] with op_wdata. After it, stat_valid=0.
- R11: Each accepted operation produces exactly one done pulse, one cycle wide. busy is high from acceptance through the done cycle, and op_valid is ignored whenever busy is high. Operation codes are 0 for load, 1 for lookup, 2 for update and 3 for write.
- R12: ee_req is a one-cycle pulse. It is only asserted while busy, and a new request waits for ee_done of the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Operation request, sampled while idle |
| op_code | input | 2 | 0 load, 1 lookup, 2 update, 3 write |
| op_index | input | 7 | Word index for lookup or write |
| op_wdata | input | 16 | Data for a word write |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Lookup result, valid from the done cycle on |
| stat_valid | output | 1 | Cache holds a validated image |
| stat_sum_err | output | 1 | Last load failed the sum check |
| stat_sig_err | output | 1 | Last load failed the signature check |
| ee_req | output | 1 | Word access request to the EEPROM engine |
| ee_we | output | 1 | Request is a write |
| ee_addr | output | 6 | EEPROM word address |
| ee_wdata | output | 16 | Write data |
| ee_done | input | 1 | Engine finished the current access |
| ee_rdata | input | 16 | Read data, valid with ee_done |

## Verification
Two things can meet in the same cycle: the completion of one operation and the arrival of the next request. In the done cycle the controller is still in FINISH with busy high, so a request presented there must be dropped. A request raised in the middle of a load must be dropped as well. The bench provokes both cases. It drives a write request during the done cycle of a cache-hit lookup, and again partway through a load. It then judges at the ports. There must be no extra done pulse and no EEPROM write, and stat_valid must stay high, because an accepted write would have cleared it.

// File: rtl/ee_cache_pkg.sv
package ee_cache_pkg;

    typedef enum logic [1:0] {
        OP_LOAD   = 2'd0,
        OP_LOOKUP = 2'd1,
        OP_UPDATE = 2'd2,
        OP_WRITE  = 2'd3
    } ee_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ISSUE,
        ST_RD_WAIT,
        ST_SUM_EVAL,
        ST_WR_ISSUE,
        ST_WR_WAIT,
        ST_FINISH
    } ee_state_e;

    localparam int SIG_W = 2;

endpackage

// File: rtl/ee_cache_ram.sv
module ee_cache_ram #(
    parameter int AW = 6,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/ee_sum_acc.sv
module ee_sum_acc #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          add_en,
    input  logic [DW-1:0] add_val,
    output logic [DW-1:0] sum
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum <= '0;
        end else if (clr) begin
            sum <= '0;
        end else if (add_en) begin
            sum <= sum + add_val;
        end
    end

    AST_SUM_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !add_en) |=> (sum == '0)); // R2

endmodule

// File: rtl/ee_image_cache.sv
module ee_image_cache
    import ee_cache_pkg::*;
#(
    parameter int            AW         = 6,
    parameter int            DW         = 16,
    parameter int            CTRL_WORD  = 10,
    parameter logic [DW-1:0] SUM_TARGET = 'hBABA,
    parameter logic [1:0]    SIG_VALID  = 2'b01
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    input  logic [1:0]    op_code,
    input  logic [AW:0]   op_index,
    input  logic [DW-1:0] op_wdata,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] rd_data,
    output logic          stat_valid,
    output logic          stat_sum_err,
    output logic          stat_sig_err,
    output logic          ee_req,
    output logic          ee_we,
    output logic [AW-1:0] ee_addr,
    output logic [DW-1:0] ee_wdata,
    input  logic          ee_done,
    input  logic [DW-1:0] ee_rdata
);
    localparam int IDXW  = AW + 1;
    localparam int WORDS = 1 << AW;

    ee_state_e      state_q, state_d;
    ee_op_e         op_in, mode_q;
    logic [AW-1:0]  addr_q, idx_q, last_addr, ram_raddr;
    logic [DW-1:0]  wdata_q, rdata_q, ram_rdata, sum;
    logic [SIG_W-1:0] sig_q, sig_pend_q;
    logic           sum_err_q, sig_err_q;
    logic           cache_ok, idx_over, accept, rd_beat, ram_we, sum_ok;

    assign op_in     = ee_op_e'(op_code);
    assign cache_ok  = (sig_q == SIG_VALID);
    assign idx_over  = (op_index >= IDXW'(WORDS));
    assign accept    = (state_q == ST_IDLE) && op_valid;
    assign rd_beat   = (state_q == ST_RD_WAIT) && ee_done;
    assign last_addr = (mode_q == OP_UPDATE) ? AW'(WORDS - 2) : AW'(WORDS - 1);
    assign ram_we    = rd_beat && (mode_q != OP_UPDATE);
    assign ram_raddr = (state_q == ST_IDLE) ? op_index[AW-1:0] : idx_q;
    assign sum_ok    = (sum == SUM_TARGET);

    ee_cache_ram #(.AW(AW), .DW(DW)) u_ram (
        .clk     (clk),
        .wr_en   (ram_we),
        .wr_addr (addr_q),
        .wr_data (ee_rdata),
        .rd_addr (ram_raddr),
        .rd_data (ram_rdata)
    );

    ee_sum_acc #(.DW(DW)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (accept),
        .add_en  (rd_beat),
        .add_val (ee_rdata),
        .sum     (sum)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (op_valid) begin
                    unique case (op_in)
                        OP_LOAD:   state_d = ST_RD_ISSUE;
                        OP_UPDATE: state_d = ST_RD_ISSUE;
                        OP_WRITE:  state_d = ST_WR_ISSUE;
                        OP_LOOKUP: state_d = (idx_over || cache_ok) ? ST_FINISH : ST_RD_ISSUE;
                        default:   state_d = ST_IDLE;
                    endcase
                end
            end
            ST_RD_ISSUE: state_d = ST_RD_WAIT;
            ST_RD_WAIT:  if (ee_done) state_d = (addr_q == last_addr) ? ST_SUM_EVAL : ST_RD_ISSUE;
            ST_SUM_EVAL: state_d = (mode_q == OP_UPDATE) ? ST_WR_ISSUE : ST_FINISH;
            ST_WR_ISSUE: state_d = ST_WR_WAIT;
            ST_WR_WAIT:  if (ee_done) state_d = ST_FINISH;
            ST_FINISH:   state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // Outputs decoded from the state
    always_comb begin
        busy   = (state_q != ST_IDLE);
        done   = (state_q == ST_FINISH);
        ee_req = (state_q == ST_RD_ISSUE) || (state_q == ST_WR_ISSUE);
        ee_we  = (state_q == ST_WR_ISSUE);
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q     <= OP_LOAD;
            addr_q     <= '0;
            idx_q      <= '0;
            wdata_q    <= '0;
            rdata_q    <= '0;
            sig_q      <= '0;
            sig_pend_q <= '0;
            sum_err_q  <= 1'b0;
            sig_err_q  <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (op_valid) begin
                        mode_q  <= op_in;
                        idx_q   <= op_index[AW-1:0];
                        wdata_q <= op_wdata;
                        addr_q  <= (op_in == OP_WRITE) ? op_index[AW-1:0] : '0;
                        if (op_in == OP_LOOKUP) begin
                            if (idx_over) begin
                                rdata_q <= '0;
                            end else if (cache_ok) begin
                                rdata_q <= ram_rdata;
                            end
                        end
                    end
                end
                ST_RD_WAIT: begin
                    if (ee_done) begin
                        if (addr_q != last_addr) begin
                            addr_q <= addr_q + 1'b1;
                        end
                        if ((mode_q != OP_UPDATE) && (addr_q == AW'(CTRL_WORD))) begin
                            sig_pend_q <= ee_rdata[DW-1 -: SIG_W];
                        end
                    end
                end
                ST_SUM_EVAL: begin
                    if (mode_q == OP_UPDATE) begin
                        wdata_q <= SUM_TARGET - sum;
                        addr_q  <= AW'(WORDS - 1);
                    end else begin
                        sum_err_q <= !sum_ok;
                        sig_err_q <= sum_ok && (sig_pend_q != SIG_VALID);
                        sig_q     <= sum_ok ? sig_pend_q : '0;
                        if (mode_q == OP_LOOKUP) begin
                            rdata_q <= (sum_ok && (sig_pend_q == SIG_VALID)) ? ram_rdata : '0;
                        end
                    end
                end
                ST_WR_ISSUE: sig_q <= '0;
                default: ;
            endcase
        end
    end

    assign rd_data      = rdata_q;
    assign stat_valid   = cache_ok;
    assign stat_sum_err = sum_err_q;
    assign stat_sig_err = sig_err_q;
    assign ee_addr      = addr_q;
    assign ee_wdata     = wdata_q;

    AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ee_req |=> !ee_req); // R12
    AST_REQ_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        ee_req |-> busy); // R12
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11
    AST_WRITE_DROPS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (ee_req && ee_we) |=> !stat_valid); // R10
    AST_VALID_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        stat_valid |-> (!stat_sum_err && !stat_sig_err)); // R3
    AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(stat_sum_err && stat_sig_err)); // R4

endmodule

// File: tb/ee_image_cache_tb.sv
module ee_image_cache_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] TARGET = 16'hBABA;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [1:0]  op_code = 2'd0;
    logic [6:0]  op_index = 7'd0;
    logic [15:0] op_wdata = 16'd0;
    logic        busy, done, stat_valid, stat_sum_err, stat_sig_err;
    logic [15:0] rd_data;
    logic        ee_req, ee_we;
    logic [5:0]  ee_addr;
    logic [15:0] ee_wdata;
    logic        ee_done = 1'b0;
    logic [15:0] ee_rdata = 16'd0;

    ee_image_cache u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .op_index(op_index), .op_wdata(op_wdata), .busy(busy), .done(done),
        .rd_data(rd_data), .stat_valid(stat_valid), .stat_sum_err(stat_sum_err),
        .stat_sig_err(stat_sig_err), .ee_req(ee_req), .ee_we(ee_we),
        .ee_addr(ee_addr), .ee_wdata(ee_wdata), .ee_done(ee_done), .ee_rdata(ee_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int failures = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // EEPROM engine model
    logic [15:0] mem [64];
    int          lat = 1;
    bit          m_busy = 0;
    int          m_cnt = 0;
    logic [5:0]  m_addr;
    bit          m_we;
    logic [15:0] m_wd;
    int          rd_cnt = 0, wr_cnt = 0, order_err = 0, overlap_err = 0, last_rd = -1;
    bit          bd_we = 0;
    logic [5:0]  bd_addr = 0;
    logic [15:0] bd_data = 0;

    always @(posedge clk) begin
        ee_done <= 1'b0;
        if (bd_we) mem[bd_addr] = bd_data;
        if (rst_n) begin
            if (m_busy) begin
                if (ee_req) overlap_err++;
                if (m_cnt <= 1) begin
                    ee_done <= 1'b1;
                    m_busy = 0;
                    if (m_we) mem[m_addr] = m_wd;
                    else ee_rdata <= mem[m_addr];
                end else begin
                    m_cnt--;
                end
            end else if (ee_req) begin
                m_busy = 1;
                m_cnt  = lat;
                m_addr = ee_addr;
                m_we   = ee_we;
                m_wd   = ee_wdata;
                if (ee_we) wr_cnt++;
                else begin
                    rd_cnt++;
                    if (ee_addr != 6'd0 && int'(ee_addr) != last_rd + 1) order_err++;
                    last_rd = int'(ee_addr);
                end
            end
        end
    end

    // Scoreboard
    typedef struct {
        bit          chk_rd;
        logic [15:0] rd;
        bit          v;
        bit          se;
        bit          ge;
    } exp_t;
    exp_t  sbq[$];
    string tagq[$];

    always @(negedge clk) begin
        exp_t  e;
        string t;
        if (rst_n && done) begin
            if (sbq.size() == 0) begin
                check(0, "R11", "unexpected done", 1, 0);
            end else begin
                e = sbq.pop_front();
                t = tagq.pop_front();
                if (e.chk_rd) check(rd_data == e.rd, t, "rd_data", rd_data, e.rd);
                check(stat_valid == e.v, t, "stat_valid", stat_valid, e.v);
                check(stat_sum_err == e.se, t, "stat_sum_err", stat_sum_err, e.se);
                check(stat_sig_err == e.ge, t, "stat_sig_err", stat_sig_err, e.ge);
            end
        end
    end

    // Watchdog
    bit wd_hit = 0;
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            wd_hit = 1;
            failures++;
            checks++;
            $display("FAIL R11 watchdog actual=busy expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Bench-side prediction
    bit          b_valid = 0, b_se = 0, b_ge = 0;
    logic [15:0] b_cache [64];

    function automatic logic [15:0] img_sum(input int n);
        logic [15:0] s = 16'd0;
        for (int i = 0; i < n; i++) s = s + mem[i];
        return s;
    endfunction

    function automatic void predict_load();
        bit ok;
        ok      = (img_sum(64) == TARGET);
        b_se    = !ok;
        b_ge    = ok && (mem[10][15:14] != 2'b01);
        b_valid = ok && (mem[10][15:14] == 2'b01);
        for (int i = 0; i < 64; i++) b_cache[i] = mem[i];
    endfunction

    task automatic bd_write(input int a, input logic [15:0] d);
        @(negedge clk);
        bd_addr = 6'(a);
        bd_data = d;
        bd_we   = 1;
        @(negedge clk);
        bd_we   = 0;
    endtask

    task automatic do_op(input logic [1:0] code, input logic [6:0] idx, input logic [15:0] wd,
                         input exp_t e, input string tag, input int exp_rd, input int exp_wr,
                         input int poke);
        int r0, w0;
        r0 = rd_cnt;
        w0 = wr_cnt;
        sbq.push_back(e);
        tagq.push_back(tag);
        @(negedge clk);
        op_valid = 1; op_code = code; op_index = idx; op_wdata = wd;
        @(negedge clk);
        op_valid = 0;
        if (poke == 1) begin
            repeat (5) @(negedge clk);
            op_valid = 1; op_code = 2'd3; op_index = 7'd0; op_wdata = 16'hDEAD;
            @(negedge clk);
            op_valid = 0;
        end
        while (!done && !wd_hit) @(negedge clk);
        if (poke == 2) begin
            op_valid = 1; op_code = 2'd3; op_index = 7'd1; op_wdata = 16'hBEEF;
        end
        @(negedge clk);
        op_valid = 0;
        check(done == 1'b0, "R11", "done width", done, 0);
        repeat (6) @(negedge clk);
        check(done == 1'b0 && busy == 1'b0, "R11", "no extra activity", {done, busy}, 0);
        check(rd_cnt - r0 == exp_rd, tag, "read count", rd_cnt - r0, exp_rd);
        check(wr_cnt - w0 == exp_wr, tag, "write count", wr_cnt - w0, exp_wr);
    endtask

    task automatic lookup(input logic [6:0] idx, input string tag, input int poke);
        exp_t e;
        int   nr;
        nr = 0;
        e.chk_rd = 1;
        if (idx >= 7'd64) begin
            e.rd = 16'd0;
        end else if (b_valid) begin
            e.rd = b_cache[idx[5:0]];
        end else begin
            predict_load();
            nr = 64;
            e.rd = b_valid ? mem[idx[5:0]] : 16'd0;
        end
        e.v = b_valid; e.se = b_se; e.ge = b_ge;
        do_op(2'd1, idx, 16'd0, e, tag, nr, 0, poke);
    endtask

    task automatic load(input string tag, input int poke);
        exp_t e;
        predict_load();
        e.chk_rd = 0; e.rd = 0; e.v = b_valid; e.se = b_se; e.ge = b_ge;
        do_op(2'd0, 7'd0, 16'd0, e, tag, 64, 0, poke);
    endtask

    task automatic wr_word(input logic [6:0] idx, input logic [15:0] d);
        exp_t e;
        b_valid = 0;
        e.chk_rd = 0; e.rd = 0; e.v = 0; e.se = b_se; e.ge = b_ge;
        do_op(2'd3, idx, d, e, "R10", 0, 1, 0);
        check(mem[idx[5:0]] == d, "R10", "written word", mem[idx[5:0]], d);
    endtask

    task automatic update();
        exp_t        e;
        logic [15:0] want;
        want = TARGET - img_sum(63);
        b_valid = 0;
        e.chk_rd = 0; e.rd = 0; e.v = 0; e.se = b_se; e.ge = b_ge;
        do_op(2'd2, 7'd0, 16'd0, e, "R9", 63, 1, 0);
        check(mem[63] == want, "R9", "checksum word", mem[63], want);
    endtask

    initial begin
        logic [15:0] s, v;
        repeat (3) @(negedge clk);
        check(!busy && !done && !ee_req, "R1", "idle outputs", {busy, done, ee_req}, 0);
        check(!stat_valid && !stat_sum_err && !stat_sig_err, "R1", "status",
              {stat_valid, stat_sum_err, stat_sig_err}, 0);
        rst_n = 1;
        @(negedge clk);
        check(!busy && !stat_valid, "R1", "after release", {busy, stat_valid}, 0);

        // Good image
        s = 16'd0;
        for (int i = 0; i < 63; i++) begin
            v = 16'(i * 16'h0137) ^ 16'h5A5A;
            if (i == 10) v = {2'b01, v[13:0]};
            s = s + v;
            bd_write(i, v);
        end
        bd_write(63, TARGET - s);

        lat = 1;
        lookup(7'd5, "R7", 0);
        lookup(7'd10, "R6", 0);
        lookup(7'd63, "R6", 0);
        lookup(7'd64, "R8", 0);
        lookup(7'd127, "R8", 0);

        lat = 3;
        load("R3", 1);
        lookup(7'd20, "R11", 2);
        check(stat_valid == 1'b1, "R11", "valid kept after ignored write", stat_valid, 1);

        wr_word(7'd3, 16'h1234);
        lookup(7'd3, "R4", 0);
        update();
        load("R3", 0);

        lat = 2;
        wr_word(7'd66, 16'h0F0F);
        update();
        bd_write(10, {2'b10, mem[10][13:0]});
        bd_write(63, TARGET - img_sum(63));
        load("R5", 0);
        lookup(7'd7, "R7", 0);

        check(order_err == 0, "R2", "read address order errors", order_err, 0);
        check(overlap_err == 0, "R12", "overlapping requests", overlap_err, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule